// File: doc/BRIEF.md
# Channel frequency word generator

This block computes the frequency word for a fractional-N synthesizer from three settings: a base word, a channel index, and a channel spacing. The spacing is given as an 8-bit mantissa and a 2-bit exponent and is worth (256 + mantissa) · 2^(exponent − 2) word units per channel. The synthesizer then runs at word · f_ref / 2^16. The block also produces an intermediate-frequency word in the same units (f_ref / 2^16 per LSB). The IF setting has a step of f_ref / 2^10, so the IF word is that setting shifted left by six. With a 26 MHz reference the widest spacing the encoding allows is about 405 kHz. A wider grid is made by choosing a smaller spacing and stepping the channel index by a fixed multiple; for example, a 333 kHz spacing with every third channel gives 1 MHz.

Retuning a running synthesizer can upset the loop. For this reason, register writes land only in a staging copy. A staging state machine has two states. `STG_SYNCED` means the staging copy equals the active settings. `STG_STAGED` means at least one write has not yet been applied. Its transitions are:
- synced→staged on any write;
- staged→synced on an idle cycle with no write;
- staged→staged otherwise.

On every cycle in `STG_STAGED` while `radio_idle` is high, the staging copy is committed to the active settings, and `commit_pulse` is high for one cycle.

An output state machine tracks the two-stage arithmetic pipeline. Its states are `PIPE_EMPTY` (after reset), `PIPE_FILL` and `PIPE_READY`. Its transitions are:
- any state→fill on a commit pulse;
- fill→ready;
- empty→empty and ready→ready otherwise.

`word_valid` is high only in `PIPE_READY`.

Top module: `chan_freq_word`

## Requirements
- R1: While and after reset (before any commit), `synth_word` and `if_word` are 0 and `word_valid` and `commit_pulse` are 0.
- R2: After a commit, `synth_word` = base + chan · (256 + spc_mant) · 2^(spc_exp − 2), using the committed values.
- R3: When spc_exp is 0 or 1, the product chan·(256+spc_mant) is shifted right by 2 or 1 and the fractional bits are dropped. When spc_exp is 3, it is shifted left by 1.
- R4: `synth_word` is 25 bits wide and never wraps. Base 0xFFFFFF with chan 255, mantissa 255 and exponent 3 gives 0x103FA01.
- R5: `if_word` equals the committed 5-bit IF setting shifted left by 6 bits.
- R6: Writes made while `radio_idle` is low do not change `synth_word`, `if_word` or the active settings, and raise no `commit_pulse`.
- R7: Staged writes are committed at the first clock edge at which `radio_idle` is high. `commit_pulse` is high for exactly the one cycle after that edge.
- R8: `synth_word` and `if_word` take their new values two clock edges after the cycle in which `commit_pulse` is high. `word_valid` is low for the one cycle in between and high from the update onward.
- R9: While `radio_idle` stays high with no write pending, no commit happens: `commit_pulse` stays low and the outputs hold.
- R10: A write in the same cycle as a commit is not lost. It stays staged, and a field that was not rewritten keeps its staged value. It is committed at the next idle edge, which raises a second `commit_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_we | input | 1 | Write strobe for the base word |
| base_wdata | input | 24 | Base frequency word |
| chan_we | input | 1 | Write strobe for the channel index |
| chan_wdata | input | 8 | Channel index |
| spcm_we | input | 1 | Write strobe for the spacing mantissa |
| spcm_wdata | input | 8 | Spacing mantissa |
| spce_we | input | 1 | Write strobe for the spacing exponent |
| spce_wdata | input | 2 | Spacing exponent |
| ifs_we | input | 1 | Write strobe for the IF setting |
| ifs_wdata | input | 5 | IF setting, step f_ref/2^10 |
| radio_idle | input | 1 | High while the radio is idle and may be retuned |
| synth_word | output | 25 | Synthesizer frequency word, f_ref/2^16 per LSB |
| if_word | output | 11 | IF word, f_ref/2^16 per LSB |
| word_valid | output | 1 | Outputs reflect the last committed settings |
| commit_pulse | output | 1 | One-cycle pulse after a commit |

## Verification
The assertions check the following on every cycle:
- a commit pulse only ever follows an idle edge;
- the active settings never move outside a commit;
- `word_valid` rises exactly two cycles after a commit pulse;
- the output word holds while valid;
- the word never falls below the committed base, so the sum cannot have wrapped.

The arithmetic itself can be shown only by the bench's scenarios, because its expected values are computed from the formula: the exponent cases with their truncation, the largest-value case and the IF scaling. The same holds for the cycle counts of commit and update, for writes that stay staged outside idle, and for a write that collides with a commit.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    localparam int BASE_W_D   = 24;
    localparam int CHAN_W_D   = 8;
    localparam int SPCM_W_D   = 8;
    localparam int SPCE_W_D   = 2;
    localparam int IFS_W_D    = 5;
    localparam int EXP_BIAS_D = 2;
    localparam int IF_SHIFT_D = 6;

    typedef enum logic {
        STG_SYNCED,
        STG_STAGED
    } stg_state_t;

    typedef enum logic [1:0] {
        PIPE_EMPTY,
        PIPE_FILL,
        PIPE_READY
    } pipe_state_t;

endpackage

// File: rtl/cfw_stage.sv
module cfw_stage
    import cfw_pkg::*;
#(
    parameter int BASE_W = BASE_W_D,
    parameter int CHAN_W = CHAN_W_D,
    parameter int SPCM_W = SPCM_W_D,
    parameter int SPCE_W = SPCE_W_D,
    parameter int IFS_W  = IFS_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              chan_we,
    input  logic [CHAN_W-1:0] chan_wdata,
    input  logic              spcm_we,
    input  logic [SPCM_W-1:0] spcm_wdata,
    input  logic              spce_we,
    input  logic [SPCE_W-1:0] spce_wdata,
    input  logic              ifs_we,
    input  logic [IFS_W-1:0]  ifs_wdata,
    input  logic              radio_idle,
    output logic [BASE_W-1:0] act_base,
    output logic [CHAN_W-1:0] act_chan,
    output logic [SPCM_W-1:0] act_spcm,
    output logic [SPCE_W-1:0] act_spce,
    output logic [IFS_W-1:0]  act_ifs,
    output logic              commit_pulse
);

    stg_state_t state_q, state_d;
    logic [BASE_W-1:0] stg_base;
    logic [CHAN_W-1:0] stg_chan;
    logic [SPCM_W-1:0] stg_spcm;
    logic [SPCE_W-1:0] stg_spce;
    logic [IFS_W-1:0]  stg_ifs;
    logic              any_we;
    logic              commit;

    assign any_we = base_we | chan_we | spcm_we | spce_we | ifs_we;
    assign commit = (state_q == STG_STAGED) && radio_idle;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STG_SYNCED: if (any_we) state_d = STG_STAGED;
            STG_STAGED: if (radio_idle && !any_we) state_d = STG_SYNCED;
            default:    state_d = STG_SYNCED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STG_SYNCED;
        else        state_q <= state_d;
    end

    // outputs: staging copy, active copy, commit pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_base     <= '0;
            stg_chan     <= '0;
            stg_spcm     <= '0;
            stg_spce     <= '0;
            stg_ifs      <= '0;
            act_base     <= '0;
            act_chan     <= '0;
            act_spcm     <= '0;
            act_spce     <= '0;
            act_ifs      <= '0;
            commit_pulse <= 1'b0;
        end else begin
            if (base_we) stg_base <= base_wdata;
            if (chan_we) stg_chan <= chan_wdata;
            if (spcm_we) stg_spcm <= spcm_wdata;
            if (spce_we) stg_spce <= spce_wdata;
            if (ifs_we)  stg_ifs  <= ifs_wdata;
            if (commit) begin
                act_base <= stg_base;
                act_chan <= stg_chan;
                act_spcm <= stg_spcm;
                act_spce <= stg_spce;
                act_ifs  <= stg_ifs;
            end
            commit_pulse <= commit;
        end
    end

    // R7: a commit is only taken on an idle edge
    a_r7_commit_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> $past(radio_idle));

    // R6: active settings change only with a commit
    a_r6_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pulse |-> $stable({act_base, act_chan, act_spcm, act_spce, act_ifs}));

endmodule

// File: rtl/cfw_offset.sv
module cfw_offset
    import cfw_pkg::*;
#(
    parameter int BASE_W   = BASE_W_D,
    parameter int CHAN_W   = CHAN_W_D,
    parameter int SPCM_W   = SPCM_W_D,
    parameter int SPCE_W   = SPCE_W_D,
    parameter int IFS_W    = IFS_W_D,
    parameter int EXP_BIAS = EXP_BIAS_D,
    parameter int IF_SHIFT = IF_SHIFT_D,
    localparam int PROD_W  = CHAN_W + SPCM_W + 1,
    localparam int MAX_LSH = (2 ** SPCE_W - 1) - EXP_BIAS,
    localparam int OFF_W   = PROD_W + MAX_LSH,
    localparam int IFW_W   = IFS_W + IF_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] act_base,
    input  logic [CHAN_W-1:0] act_chan,
    input  logic [SPCM_W-1:0] act_spcm,
    input  logic [SPCE_W-1:0] act_spce,
    input  logic [IFS_W-1:0]  act_ifs,
    output logic [BASE_W-1:0] base_q,
    output logic [OFF_W-1:0]  off_q,
    output logic [IFW_W-1:0]  ifw_q
);

    localparam logic [SPCE_W-1:0] BIAS_V = SPCE_W'(EXP_BIAS);

    logic [PROD_W-1:0] step;
    logic [PROD_W-1:0] prod;
    logic [OFF_W-1:0]  off_d;

    // spacing in quarter units: 2^SPCM_W + mantissa
    assign step = PROD_W'(act_spcm) + PROD_W'(1 << SPCM_W);
    assign prod = PROD_W'(act_chan) * step;

    always_comb begin
        if (act_spce >= BIAS_V) off_d = OFF_W'(prod) << (act_spce - BIAS_V);
        else                    off_d = OFF_W'(prod >> (BIAS_V - act_spce));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
            ifw_q  <= '0;
        end else begin
            base_q <= act_base;
            off_q  <= off_d;
            ifw_q  <= {act_ifs, {IF_SHIFT{1'b0}}};
        end
    end

    // R2: channel zero adds no offset, whatever the spacing
    a_r2_zero_channel: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act_chan) == '0) |-> (off_q == '0));

endmodule

// File: rtl/cfw_sum.sv
module cfw_sum
    import cfw_pkg::*;
#(
    parameter int BASE_W = BASE_W_D,
    parameter int OFF_W  = 18,
    parameter int IFW_W  = 11,
    localparam int WORD_W = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base_q,
    input  logic [OFF_W-1:0]  off_q,
    input  logic [IFW_W-1:0]  ifw_q,
    input  logic              commit_pulse,
    output logic [WORD_W-1:0] synth_word,
    output logic [IFW_W-1:0]  if_word,
    output logic              word_valid
);

    pipe_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (commit_pulse) begin
            state_d = PIPE_FILL;
        end else begin
            unique case (state_q)
                PIPE_EMPTY: state_d = PIPE_EMPTY;
                PIPE_FILL:  state_d = PIPE_READY;
                PIPE_READY: state_d = PIPE_READY;
                default:    state_d = PIPE_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIPE_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            synth_word <= '0;
            if_word    <= '0;
        end else begin
            synth_word <= WORD_W'(base_q) + WORD_W'(off_q);
            if_word    <= ifw_q;
        end
    end

    assign word_valid = (state_q == PIPE_READY);

    // R8: valid rises exactly two cycles after a commit pulse
    a_r8_valid_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(commit_pulse, 2));

    // R8: a valid word holds until the next commit reaches it
    a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid)) |-> $stable(synth_word));

endmodule

// File: rtl/chan_freq_word.sv
module chan_freq_word
    import cfw_pkg::*;
#(
    parameter int BASE_W   = BASE_W_D,
    parameter int CHAN_W   = CHAN_W_D,
    parameter int SPCM_W   = SPCM_W_D,
    parameter int SPCE_W   = SPCE_W_D,
    parameter int IFS_W    = IFS_W_D,
    parameter int EXP_BIAS = EXP_BIAS_D,
    parameter int IF_SHIFT = IF_SHIFT_D,
    localparam int PROD_W  = CHAN_W + SPCM_W + 1,
    localparam int OFF_W   = PROD_W + (2 ** SPCE_W - 1) - EXP_BIAS,
    localparam int WORD_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1,
    localparam int IFW_W   = IFS_W + IF_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              chan_we,
    input  logic [CHAN_W-1:0] chan_wdata,
    input  logic              spcm_we,
    input  logic [SPCM_W-1:0] spcm_wdata,
    input  logic              spce_we,
    input  logic [SPCE_W-1:0] spce_wdata,
    input  logic              ifs_we,
    input  logic [IFS_W-1:0]  ifs_wdata,
    input  logic              radio_idle,
    output logic [WORD_W-1:0] synth_word,
    output logic [IFW_W-1:0]  if_word,
    output logic              word_valid,
    output logic              commit_pulse
);

    logic [BASE_W-1:0] act_base;
    logic [CHAN_W-1:0] act_chan;
    logic [SPCM_W-1:0] act_spcm;
    logic [SPCE_W-1:0] act_spce;
    logic [IFS_W-1:0]  act_ifs;
    logic [BASE_W-1:0] base_q;
    logic [OFF_W-1:0]  off_q;
    logic [IFW_W-1:0]  ifw_q;

    cfw_stage #(
        .BASE_W(BASE_W), .CHAN_W(CHAN_W), .SPCM_W(SPCM_W),
        .SPCE_W(SPCE_W), .IFS_W(IFS_W)
    ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_wdata(base_wdata),
        .chan_we(chan_we), .chan_wdata(chan_wdata),
        .spcm_we(spcm_we), .spcm_wdata(spcm_wdata),
        .spce_we(spce_we), .spce_wdata(spce_wdata),
        .ifs_we(ifs_we),   .ifs_wdata(ifs_wdata),
        .radio_idle(radio_idle),
        .act_base(act_base), .act_chan(act_chan), .act_spcm(act_spcm),
        .act_spce(act_spce), .act_ifs(act_ifs),
        .commit_pulse(commit_pulse)
    );

    cfw_offset #(
        .BASE_W(BASE_W), .CHAN_W(CHAN_W), .SPCM_W(SPCM_W), .SPCE_W(SPCE_W),
        .IFS_W(IFS_W), .EXP_BIAS(EXP_BIAS), .IF_SHIFT(IF_SHIFT)
    ) u_offset (
        .clk(clk), .rst_n(rst_n),
        .act_base(act_base), .act_chan(act_chan), .act_spcm(act_spcm),
        .act_spce(act_spce), .act_ifs(act_ifs),
        .base_q(base_q), .off_q(off_q), .ifw_q(ifw_q)
    );

    cfw_sum #(
        .BASE_W(BASE_W), .OFF_W(OFF_W), .IFW_W(IFW_W)
    ) u_sum (
        .clk(clk), .rst_n(rst_n),
        .base_q(base_q), .off_q(off_q), .ifw_q(ifw_q),
        .commit_pulse(commit_pulse),
        .synth_word(synth_word), .if_word(if_word), .word_valid(word_valid)
    );

    // R4: a valid word never falls below the committed base (no wrap)
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !commit_pulse) |-> (synth_word >= WORD_W'(act_base)));

endmodule

// File: tb/chan_freq_word_tb_top.sv
module chan_freq_word_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [23:0] base_wdata = '0;
    logic        chan_we = 1'b0;
    logic [7:0]  chan_wdata = '0;
    logic        spcm_we = 1'b0;
    logic [7:0]  spcm_wdata = '0;
    logic        spce_we = 1'b0;
    logic [1:0]  spce_wdata = '0;
    logic        ifs_we = 1'b0;
    logic [4:0]  ifs_wdata = '0;
    logic        radio_idle = 1'b0;
    logic [24:0] synth_word;
    logic [10:0] if_word;
    logic        word_valid;
    logic        commit_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    chan_freq_word dut_i (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_wdata(base_wdata),
        .chan_we(chan_we), .chan_wdata(chan_wdata),
        .spcm_we(spcm_we), .spcm_wdata(spcm_wdata),
        .spce_we(spce_we), .spce_wdata(spce_wdata),
        .ifs_we(ifs_we),   .ifs_wdata(ifs_wdata),
        .radio_idle(radio_idle),
        .synth_word(synth_word), .if_word(if_word),
        .word_valid(word_valid), .commit_pulse(commit_pulse)
    );

    localparam int NV = 6;
    localparam logic [23:0] V_BASE [NV] = '{24'h010000, 24'h5C4EC4, 24'h000100,
                                            24'h001000, 24'h200000, 24'hFFFFFF};
    localparam logic [7:0]  V_CHAN [NV] = '{8'd0, 8'd1, 8'd3, 8'd5, 8'd7, 8'd255};
    localparam logic [7:0]  V_MANT [NV] = '{8'h00, 8'h3B, 8'h10, 8'h01, 8'h03, 8'hFF};
    localparam logic [1:0]  V_EXP  [NV] = '{2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd3};
    localparam logic [4:0]  V_IFS  [NV] = '{5'd6, 5'd12, 5'd1, 5'd31, 5'd0, 5'd31};
    localparam logic [24:0] V_WORD [NV] = '{25'h0010000, 25'h05C4FFF, 25'h0000760,
                                            25'h0001141, 25'h020038A, 25'h103FA01};
    localparam logic [10:0] V_IFW  [NV] = '{11'h180, 11'h300, 11'h040,
                                            11'h7C0, 11'h000, 11'h7C0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_all(input logic [23:0] b, input logic [7:0] c,
                             input logic [7:0] m, input logic [1:0] e,
                             input logic [4:0] f);
        base_we = 1'b1; base_wdata = b;
        chan_we = 1'b1; chan_wdata = c;
        spcm_we = 1'b1; spcm_wdata = m;
        spce_we = 1'b1; spce_wdata = e;
        ifs_we  = 1'b1; ifs_wdata  = f;
        tick();
        base_we = 1'b0; chan_we = 1'b0; spcm_we = 1'b0; spce_we = 1'b0; ifs_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [24:0] prev_word;
        logic [10:0] prev_if;

        // R1: reset state, during and after reset
        @(negedge clk);
        chk("R1 word in reset", 32'(synth_word), 0);
        chk("R1 valid in reset", 32'(word_valid), 0);
        tick();
        rst_n = 1'b1;
        tick(); tick();
        chk("R1 word after reset", 32'(synth_word), 0);
        chk("R1 if after reset", 32'(if_word), 0);
        chk("R1 valid after reset", 32'(word_valid), 0);
        chk("R1 pulse after reset", 32'(commit_pulse), 0);

        prev_word = '0;
        prev_if   = '0;

        // vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (i == 3 || i == 4) ? "R3" : ((i == 5) ? "R4" : "R2");
            radio_idle = 1'b0;
            write_all(V_BASE[i], V_CHAN[i], V_MANT[i], V_EXP[i], V_IFS[i]);
            tick(); tick(); tick();
            chk("R6 word held while busy", 32'(synth_word), 32'(prev_word));
            chk("R6 if held while busy", 32'(if_word), 32'(prev_if));
            chk("R6 no pulse while busy", 32'(commit_pulse), 0);
            radio_idle = 1'b1;
            tick();
            chk("R7 pulse after idle edge", 32'(commit_pulse), 1);
            chk("R8 word not yet updated", 32'(synth_word), 32'(prev_word));
            tick();
            chk("R7 pulse one cycle", 32'(commit_pulse), 0);
            chk("R8 valid low while filling", 32'(word_valid), 0);
            tick();
            chk(tag, 32'(synth_word), 32'(V_WORD[i]));
            chk("R5 if word", 32'(if_word), 32'(V_IFW[i]));
            chk("R8 valid after update", 32'(word_valid), 1);
            tick(); tick(); tick();
            chk("R9 no pulse idle without pending", 32'(commit_pulse), 0);
            chk("R9 word holds while idle", 32'(synth_word), 32'(V_WORD[i]));
            prev_word = V_WORD[i];
            prev_if   = V_IFW[i];
        end

        // R10: a write colliding with a commit is staged for the next idle edge
        radio_idle = 1'b0;
        write_all(24'h001000, 8'd0, 8'h00, 2'd2, 5'd2);
        tick();
        radio_idle = 1'b1;
        chan_we = 1'b1; chan_wdata = 8'd4;
        tick();
        chan_we = 1'b0;
        chk("R10 first commit pulse", 32'(commit_pulse), 1);
        tick();
        chk("R10 second commit pulse", 32'(commit_pulse), 1);
        tick();
        chk("R10 pulse ends", 32'(commit_pulse), 0);
        chk("R10 intermediate word", 32'(synth_word), 32'h1000);
        tick();
        chk("R10 final word", 32'(synth_word), 32'h1400);
        chk("R10 if kept", 32'(if_word), 32'h080);
        chk("R10 valid", 32'(word_valid), 1);

        // R6: busy write then reset-free hold, nothing leaks without idle
        radio_idle = 1'b0;
        write_all(24'h777777, 8'd9, 8'h22, 2'd1, 5'd9);
        for (int k = 0; k < 8; k++) tick();
        chk("R6 long busy hold", 32'(synth_word), 32'h1400);
        chk("R6 valid kept while busy", 32'(word_valid), 1);

        finish_run();
    end

endmodule